// File: doc/BRIEF.md
# TDM Output Clock and Frame Pulse Generator

This block derives all output timing of a time-division-multiplexed switch from one fast reference clock. A free-running tick counter divides each 125 us frame into 2^TICK_W reference ticks (8192 ticks at the default, a 65.536 MHz reference). Every output is a registered function of that counter, so each clock edge and pulse is aligned with the frame boundary at tick 0.

Three outputs run at fixed rates of 4.096, 8.192 and 16.384 MHz, and each has an active-low 8 kHz frame pulse. A fourth clock and its pulse run at a rate chosen by a 2-bit code. Three further 8 kHz pulses each start a programmable number of 8-bit channels after the frame boundary. The channel length comes from a selectable data rate. The rate codes and channel offsets are sampled once per frame at the half-frame point and take effect at the next boundary. This means a change never produces a clipped or repeated pulse.

Top module: `tdm_timing_gen`

## Requirements
- R1: A frame has 8192 ticks and wraps from 8191 to 0. While reset is held the outputs are: all clocks high, all frame pulses and offset pulses low. After reset is released, tick k (mod 8192) is reached at the k-th rising clock edge.
- R2: Fixed clocks 0, 1 and 2 have periods of 16, 8 and 4 ticks. In each period the clock is high for the first half, and a period starts at tick 0.
- R3: Fixed frame pulse n is low from half of its clock's period before tick 0 until half a period after tick 0, once per frame. The pulse is therefore one clock period wide.
- R4: The programmable clock period follows the rate code prog_rate: 0 gives 16 ticks, 1 gives 8, 2 gives 4. Code 3 gives 2 ticks when fast_en is 1 and 4 ticks when fast_en is 0.
- R5: The programmable frame pulse straddles tick 0 in the same way as R3, using the programmable clock's period.
- R6: The channel length depends on ofs_rate: 0 gives 256 ticks, 1 gives 128, 2 gives 64, 3 gives 32. Offset pulse n goes low at tick offset_n × channel length and stays low for one eighth of a channel. offset_n is ofs_chan[8n+7:8n].
- R7: An offset equal to or larger than the number of channels in a frame (8192 / channel length) wraps modulo that number.
- R8: The inputs prog_rate, fast_en, ofs_rate and ofs_chan are sampled at the edge where tick 4096 is reached. They govern the clock, the offset pulses and the trailing half of the programmable pulse from the next tick 0 onward. The leading half of the programmable pulse, before that tick 0, already uses the newly sampled rate.
- R9: Each complete programmable frame pulse is exactly one period of the rate in force after its boundary, including the first pulse after a rate change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 2^TICK_W ticks per 125 us frame |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_en | input | 1 | Enables the fastest programmable clock setting |
| prog_rate | input | 2 | Programmable clock rate code |
| ofs_rate | input | 2 | Data rate code that sets the channel length for the offsets |
| ofs_chan | input | NUM_OFS*OFS_W | Channel offsets, offset n in bits [8n+7:8n] |
| ck_fixed | output | 3 | Fixed-rate clocks: bit 0 at 4.096, bit 1 at 8.192, bit 2 at 16.384 MHz |
| fp_fixed_n | output | 3 | Active-low frame pulses for ck_fixed |
| ck_prog | output | 1 | Programmable clock |
| fp_prog_n | output | 1 | Active-low frame pulse for ck_prog |
| fp_ofs_n | output | NUM_OFS | Active-low offset frame pulses |

## Verification
Every output is registered from the next value of the tick counter. As a result, the output seen after the k-th rising edge since reset belongs to tick k mod 8192, with no extra latency. The bench samples on the falling edge and keeps its own cycle count from reset release. A new setting appears only in the frame after the half-frame edge that captured it. The bench therefore keeps a pending and an active copy of the settings, updated at cycles 4096 and 0. Every sample of the full frames is compared against a model built from those copies. Inputs change only just after a rising edge, and the model uses the inputs seen at the previous falling edge. Pulse widths are measured on each rising edge of the programmable pulse.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

  typedef struct packed {
    logic [4:0] ck_log2;  // log2 of programmable clock period in ticks
    logic [4:0] ch_log2;  // log2 of channel length in ticks
  } rate_cfg_t;

  // Clock period exponent for a rate code; tw is log2 of ticks per frame.
  function automatic logic [4:0] prog_log2(input logic [1:0] code, input logic fast,
                                           input int unsigned tw);
    int unsigned v;
    case (code)
      2'd0:    v = tw - 9;
      2'd1:    v = tw - 10;
      2'd2:    v = tw - 11;
      default: v = fast ? tw - 12 : tw - 11;
    endcase
    return v[4:0];
  endfunction

  // Channel length exponent: 32 channels per frame at code 0, doubling per step.
  function automatic logic [4:0] chan_log2(input logic [1:0] code, input int unsigned tw);
    int unsigned v;
    v = tw - 5 - 32'(code);
    return v[4:0];
  endfunction

  // Clock is high in the first half of each period.
  function automatic logic clk_high(input int unsigned tick, input logic [4:0] lg);
    int unsigned s;
    s = 32'(lg) - 32'd1;
    return ((tick >> s) & 32'd1) == 32'd0;
  endfunction

  // Active-low pulse straddling tick 0 by half a period on each side.
  function automatic logic frame_pulse_n(input int unsigned tick, input int unsigned mask,
                                         input logic [4:0] lg);
    int unsigned half;
    half = 32'd1 << (32'(lg) - 32'd1);
    return ((tick + half) & mask) >= (half << 1);
  endfunction

  // Start tick of an offset pulse; the mask gives the modulo wrap.
  function automatic int unsigned ofs_start(input int unsigned off, input logic [4:0] lg,
                                            input int unsigned mask);
    return (off << lg) & mask;
  endfunction

  // Active-low pulse one eighth of a channel long starting at start.
  function automatic logic ofs_pulse_n(input int unsigned tick, input int unsigned start,
                                       input logic [4:0] lg, input int unsigned mask);
    int unsigned w;
    w = 32'd1 << (32'(lg) - 32'd3);
    return ((tick - start) & mask) >= w;
  endfunction

endpackage

// File: rtl/tmg_frame_ctr.sv
module tmg_frame_ctr #(
  parameter int TICK_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick_q,
  output logic [TICK_W-1:0] tick_nxt,
  output logic              at_bound_nxt,
  output logic              at_mid_nxt,
  output logic              at_bound_q,
  output logic              at_mid_q
);
  localparam logic [TICK_W-1:0] LAST = '1;
  localparam logic [TICK_W-1:0] MID  = {1'b1, {(TICK_W-1){1'b0}}};

  assign tick_nxt     = tick_q + 1'b1;
  assign at_bound_nxt = (tick_nxt == '0);
  assign at_mid_nxt   = (tick_nxt == MID);
  assign at_bound_q   = (tick_q == '0);
  assign at_mid_q     = (tick_q == MID);

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_nxt;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q == LAST) |=> (tick_q == '0)); // R1

endmodule

// File: rtl/tmg_cfg_ctrl.sv
module tmg_cfg_ctrl
  import tmg_pkg::*;
#(
  parameter int TICK_W  = 13,
  parameter int NUM_OFS = 3,
  parameter int OFS_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_en,
  input  logic [1:0]               prog_rate,
  input  logic [1:0]               ofs_rate,
  input  logic [NUM_OFS*OFS_W-1:0] ofs_chan,
  input  logic                     at_mid_nxt,
  input  logic                     at_bound_nxt,
  input  logic                     at_mid_q,
  input  logic                     at_bound_q,
  output logic [4:0]               pend_ck_nxt,
  output rate_cfg_t                act_q,
  output rate_cfg_t                act_nxt,
  output logic [NUM_OFS*OFS_W-1:0] ofs_act_q,
  output logic [NUM_OFS*OFS_W-1:0] ofs_act_nxt
);
  localparam rate_cfg_t CFG_RST = '{ck_log2: prog_log2(2'd0, 1'b0, TICK_W),
                                     ch_log2: chan_log2(2'd0, TICK_W)};

  rate_cfg_t                pend_q, pend_nxt;
  logic [NUM_OFS*OFS_W-1:0] ofs_pend_q, ofs_pend_nxt;

  // Capture at half frame, apply at frame boundary.
  always_comb begin
    pend_nxt     = pend_q;
    ofs_pend_nxt = ofs_pend_q;
    if (at_mid_nxt) begin
      pend_nxt.ck_log2 = prog_log2(prog_rate, fast_en, TICK_W);
      pend_nxt.ch_log2 = chan_log2(ofs_rate, TICK_W);
      ofs_pend_nxt     = ofs_chan;
    end
    act_nxt     = at_bound_nxt ? pend_q     : act_q;
    ofs_act_nxt = at_bound_nxt ? ofs_pend_q : ofs_act_q;
  end

  assign pend_ck_nxt = pend_nxt.ck_log2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= CFG_RST;
      act_q      <= CFG_RST;
      ofs_pend_q <= '0;
      ofs_act_q  <= '0;
    end else begin
      pend_q     <= pend_nxt;
      act_q      <= act_nxt;
      ofs_pend_q <= ofs_pend_nxt;
      ofs_act_q  <= ofs_act_nxt;
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bound_q |-> ($stable(act_q) && $stable(ofs_act_q))); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !at_mid_q |-> ($stable(pend_q) && $stable(ofs_pend_q))); // R8

endmodule

// File: rtl/tmg_clk_pulse.sv
module tmg_clk_pulse
  import tmg_pkg::*;
#(
  parameter int TICK_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_nxt,
  input  logic              at_bound_q,
  input  logic [4:0]        ck_log2_nxt,
  input  logic [4:0]        fp_log2_nxt,
  input  logic [4:0]        ck_log2_q,
  output logic              ck,
  output logic              fp_n
);
  localparam int unsigned FMASK = (32'd1 << TICK_W) - 32'd1;

  logic ck_nxt, fp_n_nxt;
  assign ck_nxt   = clk_high(32'(tick_nxt), ck_log2_nxt);
  assign fp_n_nxt = frame_pulse_n(32'(tick_nxt), FMASK, fp_log2_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck   <= 1'b1;
      fp_n <= 1'b0;
    end else begin
      ck   <= ck_nxt;
      fp_n <= fp_n_nxt;
    end
  end

  // Width monitor for the assertions.
  logic [TICK_W-1:0] low_run;
  logic              armed;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      armed   <= 1'b0;
    end else begin
      low_run <= fp_n ? '0 : low_run + 1'b1;
      armed   <= armed | fp_n;
    end
  end

  AST_BOUND_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    at_bound_q |-> (ck && !fp_n)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(fp_n)) |-> (low_run == (TICK_W'(1) << ck_log2_q))); // R9

endmodule

// File: rtl/tmg_ofs_pulse.sv
module tmg_ofs_pulse
  import tmg_pkg::*;
#(
  parameter int TICK_W = 13,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_nxt,
  input  logic [TICK_W-1:0] tick_q,
  input  logic [OFS_W-1:0]  off_nxt,
  input  logic [4:0]        ch_log2_nxt,
  input  logic [4:0]        ch_log2_q,
  output logic              fp_n
);
  localparam int unsigned FMASK = (32'd1 << TICK_W) - 32'd1;

  int unsigned start_nxt;
  logic        fp_n_nxt;
  assign start_nxt = ofs_start(32'(off_nxt), ch_log2_nxt, FMASK);
  assign fp_n_nxt  = ofs_pulse_n(32'(tick_nxt), start_nxt, ch_log2_nxt, FMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) fp_n <= 1'b0;
    else        fp_n <= fp_n_nxt;
  end

  logic [TICK_W-1:0] low_run;
  logic              armed;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      armed   <= 1'b0;
    end else begin
      low_run <= fp_n ? '0 : low_run + 1'b1;
      armed   <= armed | fp_n;
    end
  end

  AST_OFS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(fp_n)) |-> (low_run == (TICK_W'(1) << (ch_log2_q - 5'd3)))); // R6
  AST_OFS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fp_n) |-> ((tick_q & ~({TICK_W{1'b1}} << ch_log2_q)) == '0)); // R7

endmodule

// File: rtl/tdm_timing_gen.sv
module tdm_timing_gen
  import tmg_pkg::*;
#(
  parameter int TICK_W  = 13,
  parameter int NUM_OFS = 3,
  parameter int OFS_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_en,
  input  logic [1:0]               prog_rate,
  input  logic [1:0]               ofs_rate,
  input  logic [NUM_OFS*OFS_W-1:0] ofs_chan,
  output logic [2:0]               ck_fixed,
  output logic [2:0]               fp_fixed_n,
  output logic                     ck_prog,
  output logic                     fp_prog_n,
  output logic [NUM_OFS-1:0]       fp_ofs_n
);
  localparam int NUM_FIX = 3;

  logic [TICK_W-1:0]        tick_q, tick_nxt;
  logic                     at_bound_nxt, at_mid_nxt, at_bound_q, at_mid_q;
  logic [4:0]               pend_ck_nxt;
  rate_cfg_t                act_q, act_nxt;
  logic [NUM_OFS*OFS_W-1:0] ofs_act_q, ofs_act_nxt;
  logic [4:0]               prog_fp_log2_nxt;

  tmg_frame_ctr #(.TICK_W(TICK_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .tick_nxt(tick_nxt),
    .at_bound_nxt(at_bound_nxt), .at_mid_nxt(at_mid_nxt),
    .at_bound_q(at_bound_q), .at_mid_q(at_mid_q));

  tmg_cfg_ctrl #(.TICK_W(TICK_W), .NUM_OFS(NUM_OFS), .OFS_W(OFS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .prog_rate(prog_rate),
    .ofs_rate(ofs_rate), .ofs_chan(ofs_chan),
    .at_mid_nxt(at_mid_nxt), .at_bound_nxt(at_bound_nxt),
    .at_mid_q(at_mid_q), .at_bound_q(at_bound_q),
    .pend_ck_nxt(pend_ck_nxt), .act_q(act_q), .act_nxt(act_nxt),
    .ofs_act_q(ofs_act_q), .ofs_act_nxt(ofs_act_nxt));

  // Fixed-rate clocks: each index doubles the rate.
  for (genvar i = 0; i < NUM_FIX; i++) begin : g_fix
    localparam logic [4:0] FL = 5'(TICK_W - 9 - i);
    tmg_clk_pulse #(.TICK_W(TICK_W)) u_fix (
      .clk(clk), .rst_n(rst_n), .tick_nxt(tick_nxt), .at_bound_q(at_bound_q),
      .ck_log2_nxt(FL), .fp_log2_nxt(FL), .ck_log2_q(FL),
      .ck(ck_fixed[i]), .fp_n(fp_fixed_n[i]));
  end

  // The leading half of the pulse (second half of frame) uses the pending rate.
  assign prog_fp_log2_nxt = tick_nxt[TICK_W-1] ? pend_ck_nxt : act_nxt.ck_log2;

  tmg_clk_pulse #(.TICK_W(TICK_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .tick_nxt(tick_nxt), .at_bound_q(at_bound_q),
    .ck_log2_nxt(act_nxt.ck_log2), .fp_log2_nxt(prog_fp_log2_nxt),
    .ck_log2_q(act_q.ck_log2), .ck(ck_prog), .fp_n(fp_prog_n));

  for (genvar n = 0; n < NUM_OFS; n++) begin : g_ofs
    tmg_ofs_pulse #(.TICK_W(TICK_W), .OFS_W(OFS_W)) u_ofs (
      .clk(clk), .rst_n(rst_n), .tick_nxt(tick_nxt), .tick_q(tick_q),
      .off_nxt(ofs_act_nxt[n*OFS_W +: OFS_W]), .ch_log2_nxt(act_nxt.ch_log2),
      .ch_log2_q(act_q.ch_log2), .fp_n(fp_ofs_n[n]));
  end

endmodule

// File: tb/test_tdm_timing_gen.sv
module test_tdm_timing_gen;
  localparam int FRAME = 8192;
  localparam int HALF  = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_en = 1'b0;
  logic [1:0] prog_rate = 2'd0;
  logic [1:0] ofs_rate = 2'd0;
  logic [23:0] ofs_chan = '0;
  logic [2:0] ck_fixed, fp_fixed_n, fp_ofs_n;
  logic       ck_prog, fp_prog_n;

  always #2 clk = ~clk;  // 250 MHz

  tdm_timing_gen i_tdm_timing_gen (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .prog_rate(prog_rate),
    .ofs_rate(ofs_rate), .ofs_chan(ofs_chan), .ck_fixed(ck_fixed),
    .fp_fixed_n(fp_fixed_n), .ck_prog(ck_prog), .fp_prog_n(fp_prog_n),
    .fp_ofs_n(fp_ofs_n));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // vector: {prog_rate, fast_en, ofs_rate, off0, off1, off2}
  localparam logic [28:0] VECS [0:6] = '{
    {2'd0, 1'b0, 2'd0, 8'd0,   8'd1,   8'd31},
    {2'd1, 1'b0, 2'd1, 8'd5,   8'd63,  8'd64},   // R7 64 of 64 wraps
    {2'd2, 1'b0, 2'd2, 8'd127, 8'd0,   8'd200},  // R7 200 of 128 wraps
    {2'd3, 1'b1, 2'd3, 8'd255, 8'd1,   8'd128},  // R4 fastest
    {2'd3, 1'b0, 2'd0, 8'd40,  8'd33,  8'd2},    // R4 fallback, R7 wrap
    {2'd0, 1'b1, 2'd3, 8'd17,  8'd100, 8'd250},
    {2'd3, 1'b1, 2'd0, 8'd31,  8'd0,   8'd16}
  };
  localparam logic [28:0] LATE = {2'd1, 1'b1, 2'd2, 8'd9, 8'd99, 8'd130};

  task automatic apply(input logic [28:0] v);
    @(posedge clk); #1;
    prog_rate = v[28:27]; fast_en = v[26]; ofs_rate = v[25:24];
    ofs_chan = {v[7:0], v[15:8], v[23:16]};
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic wait_tick(input int n);
    do @(negedge clk); while ((cyc % FRAME) != n);
  endtask

  function automatic int per_of(input logic [1:0] c, input logic f);
    case (c)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 4;
      default: return f ? 2 : 4;
    endcase
  endfunction

  function automatic int chan_of(input logic [1:0] c);
    return 256 >> c;
  endfunction

  // Model state
  int m_pend_p, m_act_p, m_pend_ch, m_act_ch;
  int m_pend_off[3], m_act_off[3];
  logic [1:0] prv_rate, prv_orate; logic prv_fast; logic [23:0] prv_chan;
  bit g_bad[5]; int g_act[5], g_exp[5];
  int run; bit armed;

  task automatic note(input int g, input int a, input int e);
    if (a != e && !g_bad[g]) begin g_bad[g] = 1; g_act[g] = a; g_exp[g] = e; end
  endtask

  always @(negedge clk) begin
    int t, p, ch, st, fp3p;
    logic [2:0] e_ck, e_fp, e_ofs;
    if (!rst_n) begin
      m_pend_p = 16; m_act_p = 16; m_pend_ch = 256; m_act_ch = 256;
      for (int k = 0; k < 3; k++) begin m_pend_off[k] = 0; m_act_off[k] = 0; end
      for (int g = 0; g < 5; g++) g_bad[g] = 0;
      run = 0; armed = 0;
    end else begin
      t = cyc % FRAME;
      if (t == 0) begin
        m_act_p = m_pend_p; m_act_ch = m_pend_ch;
        for (int k = 0; k < 3; k++) m_act_off[k] = m_pend_off[k];
      end
      if (t == HALF) begin
        m_pend_p = per_of(prv_rate, prv_fast); m_pend_ch = chan_of(prv_orate);
        for (int k = 0; k < 3; k++) m_pend_off[k] = int'(prv_chan[k*8 +: 8]);
      end
      for (int k = 0; k < 3; k++) begin
        p = 16 >> k;
        e_ck[k] = (t % p) < p / 2;
        e_fp[k] = !((t < p / 2) || (t >= FRAME - p / 2));
      end
      note(0, int'(ck_fixed), int'(e_ck));
      note(1, int'(fp_fixed_n), int'(e_fp));
      note(2, int'(ck_prog), int'((t % m_act_p) < m_act_p / 2));
      fp3p = (t >= HALF) ? m_pend_p : m_act_p;
      note(3, int'(fp_prog_n), int'(!((t < fp3p / 2) || (t >= FRAME - fp3p / 2))));
      ch = m_act_ch;
      for (int k = 0; k < 3; k++) begin
        st = (m_act_off[k] % (FRAME / ch)) * ch;
        e_ofs[k] = !((t >= st) && (t < st + ch / 8));
      end
      note(4, int'(fp_ofs_n), int'(e_ofs));
      // R9: width of each complete programmable pulse
      if (!fp_prog_n) run++;
      else begin
        if (armed && run > 0) check("R9 programmable pulse width", run == m_act_p, run, m_act_p);
        run = 0; armed = 1;
      end
      if (t == FRAME - 1) begin
        check("R1 R2 fixed clocks", !g_bad[0], g_act[0], g_exp[0]);
        check("R3 fixed frame pulses", !g_bad[1], g_act[1], g_exp[1]);
        check("R4 R8 programmable clock", !g_bad[2], g_act[2], g_exp[2]);
        check("R5 R8 programmable pulse", !g_bad[3], g_act[3], g_exp[3]);
        check("R6 R7 R8 offset pulses", !g_bad[4], g_act[4], g_exp[4]);
        for (int g = 0; g < 5; g++) g_bad[g] = 0;
      end
    end
    prv_rate = prog_rate; prv_fast = fast_en; prv_orate = ofs_rate; prv_chan = ofs_chan;
  end

  task automatic reset_check;
    logic [10:0] a;
    @(negedge clk);
    a = {ck_fixed, fp_fixed_n, ck_prog, fp_prog_n, fp_ofs_n};
    check("R1 reset state", a == 11'b111_000_1_0_000, int'(a), int'(11'b111_000_1_0_000));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    reset_check();
    @(posedge clk); #1 rst_n = 1'b1;
    wait_tick(200);
    // table walk: each vector owns one full frame
    for (int v = 0; v < 7; v++) begin
      apply(VECS[v]);
      repeat (FRAME) @(posedge clk);
    end
    // R8: change after the half-frame point is deferred one extra frame
    wait_tick(6000);
    apply(LATE);
    repeat (2 * FRAME) @(posedge clk);
    // R1: reset mid-frame, then rerun from tick 0
    wait_tick(3000);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    reset_check();
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2 * FRAME + 10) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule